// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave

This block is a two-wire bus slave that stands in front of a small byte-wide storage array (128 x 8 by default) and behaves like a serial EEPROM. It samples the clock and data lines through synchronizers, finds START and STOP conditions, and recognises its select byte. After that it handles single-byte writes, page writes, reads at the current address, random reads and sequential reads. The data line is driven only as an open-drain pull-down enable.

Write data goes first into a one-page buffer. The buffer is copied into the array only when the master closes the write with a valid STOP. That copy starts a self-timed programming interval, counted in clocks. During that interval the slave stays off the bus and does not acknowledge its select byte. A write-control input blocks the storing of data bytes. When it is high, the slave refuses to acknowledge those bytes but still acknowledges the select and address bytes.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset the slave releases SDA (sda_oe_o = 0) and every array byte reads as 8'hFF.
- R2: A select byte is acknowledged only when its bits 7:4 equal 4'b1010. Bits 3:1 are ignored, and bit 0 = 1 requests a read. Any other upper nibble gets no acknowledge, and the bus is ignored until the next START.
- R3: In a write, the slave pulls SDA low in the 9th clock after each of these bytes: the select byte, the word address byte (of which bits 6:0 are used), and each data byte. The data is stored in the array once a STOP follows.
- R4: A page write takes up to 16 data bytes. Between bytes only the low 4 address bits advance, so writes wrap inside the current 16-byte page, and bytes of the page that were not written keep their values.
- R5: If a write ends with a repeated START and no STOP, nothing is stored and no programming interval starts.
- R6: While wc_i is high, the select and address bytes are still acknowledged but data bytes are not. Nothing is stored and no programming interval starts.
- R7: After the STOP of a write, the slave is busy for WR_CYCLES clocks. While busy it never drives SDA and does not acknowledge its select byte.
- R8: A random read works as follows. A write select and the address are sent, then a repeated START and a read select. The read returns the byte at that address.
- R9: A sequential read returns successive bytes for as long as the master acknowledges. The address runs across the whole array and wraps from 127 to 0.
- R10: A read at the current address, with no address phase, returns the byte one past the last byte read.
- R11: A master no-acknowledge ends a read. SDA then stays released while the master keeps clocking, until the next START.
- R12: The SDA pull-down enable is switched on only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level |
| wc_i | input | 1 | Write control: high blocks storing of data bytes |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
A wrong control state shows up at the single output within one bit slot. If the slave goes out of step with the byte, it acknowledges in the wrong clock or does not acknowledge at all, and the master sees that in the very 9th slot it samples. A wrong address pointer or page buffer only shows up on a later read, as a wrong or unchanged byte. For that reason every page of the array is written with a computed pattern and read back in one sequential pass that crosses the wrap point. A programming interval of the wrong length is caught by probing the select acknowledge just after and well after a STOP.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEL   = 3'd1,
        ST_WADDR = 3'd2,
        ST_WDATA = 3'd3,
        ST_RDATA = 3'd4
    } eep_state_e;
endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    // bit 0 = SCL, bit 1 = SDA; two sync stages then one history stage
    logic [1:0] s1_d, s1_q, s2_d, s2_q, s3_d, s3_q;

    always_comb begin
        s1_d = {sda_i, scl_i};
        s2_d = s1_q;
        s3_d = s2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 2'b11;
            s2_q <= 2'b11;
            s3_q <= 2'b11;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            s3_q <= s3_d;
        end
    end

    assign scl_o      = s2_q[0];
    assign sda_o      = s2_q[1];
    assign scl_rise_o = s2_q[0] & ~s3_q[0];
    assign scl_fall_o = ~s2_q[0] & s3_q[0];
    assign start_o    = s2_q[0] & s3_q[0] & ~s2_q[1] & s3_q[1];
    assign stop_o     = s2_q[0] & s3_q[0] & s2_q[1] & ~s3_q[1];
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int DEPTH = 128,
    parameter int PAGE  = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            commit_i,
    input  logic [$clog2(DEPTH)-$clog2(PAGE)-1:0] page_sel_i,
    input  logic [PAGE-1:0][7:0]            page_data_i,
    input  logic [PAGE-1:0]                 page_mask_i,
    input  logic [$clog2(DEPTH)-1:0]        rd_addr_i,
    output logic [7:0]                      rd_data_o
);
    localparam int PW = $clog2(PAGE);

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (commit_i) begin
            for (int i = 0; i < PAGE; i++) begin
                if (page_mask_i[i])
                    mem_d[{page_sel_i, PW'(i)}] = page_data_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave #(
    parameter int         MEM_DEPTH  = 128,
    parameter int         PAGE_BYTES = 16,
    parameter int         WR_CYCLES  = 64,
    parameter logic [3:0] DEV_TYPE   = 4'b1010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wc_i,
    output logic sda_oe_o
);
    import eep_pkg::*;

    localparam int AW = $clog2(MEM_DEPTH);
    localparam int PW = $clog2(PAGE_BYTES);

    typedef struct packed {
        eep_state_e                 st;
        logic [3:0]                 bits;
        logic                       ackph;
        logic                       mack;
        logic [7:0]                 sh;
        logic [AW-1:0]              addr;
        logic                       oe;
        logic                       pend;
        logic                       commit;
        logic [PAGE_BYTES-1:0][7:0] pbuf;
        logic [PAGE_BYTES-1:0]      pmask;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    logic       scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic       busy, commit;
    logic [7:0] rd_data;

    eep_pin_sync i_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_evt), .stop_o(stop_evt)
    );

    eep_wr_timer #(.CYCLES(WR_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .start_i(commit), .busy_o(busy)
    );

    eep_array #(.DEPTH(MEM_DEPTH), .PAGE(PAGE_BYTES)) i_array (
        .clk(clk), .rst_n(rst_n), .commit_i(commit),
        .page_sel_i(ctl_q.addr[AW-1:PW]), .page_data_i(ctl_q.pbuf),
        .page_mask_i(ctl_q.pmask), .rd_addr_i(ctl_q.addr), .rd_data_o(rd_data)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.commit = 1'b0;
        if (start_evt) begin
            ctl_d.st    = ST_SEL;
            ctl_d.bits  = '0;
            ctl_d.ackph = 1'b0;
            ctl_d.oe    = 1'b0;
            ctl_d.pend  = 1'b0;
            ctl_d.sh    = '0;
        end else if (stop_evt) begin
            ctl_d.st     = ST_IDLE;
            ctl_d.oe     = 1'b0;
            ctl_d.ackph  = 1'b0;
            ctl_d.commit = ctl_q.pend & ~busy;
            ctl_d.pend   = 1'b0;
        end else begin
            case (ctl_q.st)
                ST_SEL, ST_WADDR, ST_WDATA: begin
                    if (scl_rise && ctl_q.bits != 4'd8) begin
                        ctl_d.sh   = {ctl_q.sh[6:0], sda_s};
                        ctl_d.bits = ctl_q.bits + 4'd1;
                    end else if (scl_fall && ctl_q.bits == 4'd8 && !ctl_q.ackph) begin
                        ctl_d.ackph = 1'b1;
                        if (ctl_q.st == ST_SEL) begin
                            if (ctl_q.sh[7:4] == DEV_TYPE && !busy) begin
                                ctl_d.oe = 1'b1;
                            end else begin
                                ctl_d.st    = ST_IDLE;
                                ctl_d.ackph = 1'b0;
                            end
                        end else if (ctl_q.st == ST_WADDR) begin
                            ctl_d.oe    = 1'b1;
                            ctl_d.addr  = ctl_q.sh[AW-1:0];
                            ctl_d.pmask = '0;
                        end else if (!wc_i) begin
                            ctl_d.oe                          = 1'b1;
                            ctl_d.pbuf[ctl_q.addr[PW-1:0]]    = ctl_q.sh;
                            ctl_d.pmask[ctl_q.addr[PW-1:0]]   = 1'b1;
                            ctl_d.pend                        = 1'b1;
                            ctl_d.addr[PW-1:0]                = ctl_q.addr[PW-1:0] + PW'(1);
                        end else begin
                            ctl_d.st    = ST_IDLE;
                            ctl_d.ackph = 1'b0;
                        end
                    end else if (scl_fall && ctl_q.ackph) begin
                        ctl_d.oe    = 1'b0;
                        ctl_d.ackph = 1'b0;
                        ctl_d.bits  = '0;
                        if (ctl_q.st == ST_SEL) begin
                            if (ctl_q.sh[0]) begin
                                ctl_d.st = ST_RDATA;
                                ctl_d.sh = rd_data;
                                ctl_d.oe = ~rd_data[7];
                            end else begin
                                ctl_d.st = ST_WADDR;
                            end
                        end else if (ctl_q.st == ST_WADDR) begin
                            ctl_d.st = ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && ctl_q.bits != 4'd8) begin
                        ctl_d.bits = ctl_q.bits + 4'd1;
                    end else if (scl_rise && !ctl_q.ackph) begin
                        ctl_d.mack  = ~sda_s;
                        ctl_d.ackph = 1'b1;
                    end else if (scl_fall && !ctl_q.ackph && ctl_q.bits != 4'd8) begin
                        ctl_d.sh = {ctl_q.sh[6:0], 1'b0};
                        ctl_d.oe = ~ctl_q.sh[6];
                    end else if (scl_fall && !ctl_q.ackph) begin
                        ctl_d.oe   = 1'b0;
                        ctl_d.addr = ctl_q.addr + AW'(1);
                    end else if (scl_fall) begin
                        ctl_d.ackph = 1'b0;
                        ctl_d.bits  = '0;
                        if (ctl_q.mack) begin
                            ctl_d.sh = rd_data;
                            ctl_d.oe = ~rd_data[7];
                        end else begin
                            ctl_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign commit   = ctl_q.commit;
    assign sda_oe_o = ctl_q.oe;
endmodule

// File: rtl/eep_i2c_checker.sv
module eep_i2c_checker #(
    parameter int WR_CYCLES = 64
) (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe,
    input logic busy,
    input logic commit,
    input logic stop_evt
);
    logic [31:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_cnt <= '0;
        else if (!busy) busy_cnt <= '0;
        else            busy_cnt <= busy_cnt + 32'd1;
    end

    a_r12_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    a_r7_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_cnt == 32'(WR_CYCLES));

    a_r3_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(stop_evt));

    a_r7_commit_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(!busy));
endmodule

bind eep_i2c_slave eep_i2c_checker #(.WR_CYCLES(WR_CYCLES)) i_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o),
    .busy(busy), .commit(commit), .stop_evt(stop_evt)
);

// File: tb/test_eep_i2c_slave.sv
module test_eep_i2c_slave;
    localparam int WRC = 1000;
    localparam int L   = 6;
    localparam int H   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wc = 1'b0;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    int n_tests = 0;
    int n_fail  = 0;
    int r12_viol = 0;
    logic oe_prev = 1'b0;

    always #5 clk = ~clk;

    eep_i2c_slave #(.WR_CYCLES(WRC)) i_eep_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .wc_i(wc), .sda_oe_o(sda_oe)
    );

    // R12: pull-down enable must not change while the SCL pin is high
    always @(negedge clk) begin
        if (rst_n && scl_m && sda_oe !== oe_prev) r12_viol++;
        oe_prev <= sda_oe;
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(L);
        scl_m = 1'b1; wclk(H);
        sda_m = 1'b0; wclk(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(L);
        scl_m = 1'b1; wclk(H);
        sda_m = 1'b1; wclk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            wclk(L); sda_m = b[i];
            wclk(L); scl_m = 1'b1;
            wclk(H); scl_m = 1'b0;
        end
        wclk(L); sda_m = 1'b1;
        wclk(L); scl_m = 1'b1;
        wclk(H / 2); ack = ~sda_line;
        wclk(H / 2); scl_m = 1'b0;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wclk(2 * L); scl_m = 1'b1;
            wclk(H / 2); b[i] = sda_line;
            wclk(H / 2); scl_m = 1'b0;
        end
        wclk(L); sda_m = ~mack;
        wclk(L); scl_m = 1'b1;
        wclk(H); scl_m = 1'b0;
        wclk(1); sda_m = 1'b1;
    endtask

    function automatic logic [7:0] pat(int a);
        return 8'((a * 29 + 7) & 255);
    endfunction

    task automatic rand_read(input logic [6:0] a, input string req, output logic [7:0] d);
        logic ack;
        bus_start();
        send_byte(8'hA0, ack); chk(req, ack, 1);
        send_byte({1'b0, a}, ack); chk(req, ack, 1);
        bus_start();
        send_byte(8'hA1, ack); chk(req, ack, 1);
        read_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic page_write(input logic [6:0] a, input int n, input int base, input string req);
        logic ack;
        bus_start();
        send_byte(8'hA0, ack); chk(req, ack, 1);
        send_byte({1'b0, a}, ack); chk(req, ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(pat(base + i), ack); chk(req, ack, 1);
        end
        bus_stop();
        wclk(WRC + 100);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        wclk(5); rst_n = 1'b1; wclk(5);

        // R1: reset state
        chk("R1", sda_oe, 0);
        rand_read(7'd0, "R1", d);   chk("R1", d, 8'hFF);
        rand_read(7'd127, "R1", d); chk("R1", d, 8'hFF);

        // R2: select nibble sweep, chip-enable bits set to odd values
        for (int nib = 0; nib < 16; nib++) begin
            bus_start();
            send_byte({4'(nib), 4'b0110}, ack);
            chk("R2", ack, (nib == 10) ? 1 : 0);
            bus_stop();
        end

        // R3 byte write, R7 busy probe, R8 readback
        bus_start();
        send_byte(8'hA0, ack); chk("R3", ack, 1);
        send_byte(8'h05, ack); chk("R3", ack, 1);
        send_byte(8'h3C, ack); chk("R3", ack, 1);
        bus_stop();
        bus_start();
        send_byte(8'hA0, ack); chk("R7", ack, 0);
        bus_stop();
        wclk(WRC + 100);
        bus_start();
        send_byte(8'hA0, ack); chk("R7", ack, 1);
        bus_stop();
        rand_read(7'h05, "R8", d); chk("R3", d, 8'h3C);

        // R4: page wrap from offset 14 of page 1
        page_write(7'h1E, 4, 200, "R4");
        rand_read(7'h1E, "R4", d); chk("R4", d, pat(200));
        rand_read(7'h1F, "R4", d); chk("R4", d, pat(201));
        rand_read(7'h10, "R4", d); chk("R4", d, pat(202));
        rand_read(7'h11, "R4", d); chk("R4", d, pat(203));
        rand_read(7'h12, "R4", d); chk("R4", d, 8'hFF);
        rand_read(7'h20, "R4", d); chk("R4", d, 8'hFF);

        // R5: write abandoned by repeated START
        bus_start();
        send_byte(8'hA0, ack); chk("R5", ack, 1);
        send_byte(8'h40, ack); chk("R5", ack, 1);
        send_byte(8'h55, ack); chk("R5", ack, 1);
        rand_read(7'h40, "R5", d); chk("R5", d, 8'hFF);
        bus_start();
        send_byte(8'hA0, ack); chk("R5", ack, 1);
        bus_stop();

        // R6: write control
        wc = 1'b1;
        bus_start();
        send_byte(8'hA0, ack); chk("R6", ack, 1);
        send_byte(8'h50, ack); chk("R6", ack, 1);
        send_byte(8'h77, ack); chk("R6", ack, 0);
        bus_stop();
        wc = 1'b0;
        rand_read(7'h50, "R6", d); chk("R6", d, 8'hFF);

        // R9: fill every page, read whole array across the wrap
        for (int p = 0; p < 8; p++) page_write(7'(p * 16), 16, p * 16, "R9");
        bus_start();
        send_byte(8'hA0, ack); chk("R9", ack, 1);
        send_byte(8'h00, ack); chk("R9", ack, 1);
        bus_start();
        send_byte(8'hA1, ack); chk("R9", ack, 1);
        for (int a = 0; a < 128; a++) begin
            read_byte(1'b1, d); chk("R9", d, pat(a));
        end
        read_byte(1'b0, d); chk("R9", d, pat(0));
        bus_stop();

        // R10: current-address reads
        bus_start();
        send_byte(8'hA1, ack); chk("R10", ack, 1);
        read_byte(1'b0, d); chk("R10", d, pat(1));
        // R11: extra clocks after master no-acknowledge
        read_byte(1'b0, d); chk("R11", d, 8'hFF);
        chk("R11", sda_oe, 0);
        bus_stop();
        bus_start();
        send_byte(8'hA1, ack); chk("R10", ack, 1);
        read_byte(1'b0, d); chk("R10", d, pat(2));
        bus_stop();

        chk("R12", r12_viol, 0);
        summary();
        $finish;
    end
endmodule